// File: doc/BRIEF.md
# Reversible Gate Cell Library

This block is a small library of combinational reversible gate cells, gathered behind one wrapper. Every cell has as many outputs as inputs, and it maps input vectors one-to-one onto output vectors, so no information is lost. Seven cells are offered:

- controlled-NOT (Feynman)
- two-target controlled-NOT (double Feynman)
- Toffoli
- Fredkin
- Peres
- the four-line HNG gate, which acts as a full adder
- the TR gate

A compile-time parameter picks one cell. The wrapper always exposes four generic inputs (`a` to `d`) and four generic outputs (`p` to `s`). Outputs that the chosen cell does not have are held at zero. Inputs that it does not use are ignored.

A second parameter, `LANES`, makes every port a vector. The chosen gate is then applied independently on each bit index, giving a bit-sliced array of identical cells.

The wrapper also drives two constant outputs. The first is the quantum cost of the chosen gate. The second is its garbage count, defined here as the number of outputs that only repeat an input unchanged. Higher-level code uses these two values to tally the cost of composite reversible designs.

Top module: `rev_gate_cell`

## Requirements
- R1: With the gate selector at 0 (controlled-NOT), p = a and q = a ^ b. The cost output is 1.
- R2: With selector 1 (two-target controlled-NOT), p = a, q = a ^ b and r = a ^ c. The cost output is 2.
- R3: With selector 2 (Toffoli), p = a, q = b and r = (a & b) ^ c. The cost output is 5.
- R4: With selector 3 (Fredkin), p = a. When a is 1, b and c are exchanged: q = c and r = b. Otherwise q = b and r = c. The cost output is 5.
- R5: With selector 4 (Peres), p = a, q = a ^ b and r = (a & b) ^ c. The cost output is 4.
- R6: With selector 5 (HNG), p = a, q = b, r = a ^ b ^ c and s = ((a ^ b) & c) ^ (a & b) ^ d. The cost output is 6. With d = 0, r is the full-adder sum of a, b and c, and s is the carry.
- R7: With selector 6 (TR), p = a, q = a ^ b and r = (a & ~b) ^ c. The cost output is 4.
- R8: The active width is 2 for selector 0, 4 for selector 5, and 3 for all other selectors. Outputs above the active width are 0. Inputs above the active width have no effect on any output.
- R9: Each gate is a bijection. Over all vectors of the active inputs, no two input vectors give the same output vector.
- R10: The garbage output equals the number of outputs that merely copy an input. For selectors 0 to 6 in order, the values are 1, 1, 2, 1, 1, 2, 1.
- R11: With `LANES` greater than 1, bit i of each output depends only on bit i of the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | LANES | Generic input line A, one bit per lane |
| b | input | LANES | Generic input line B |
| c | input | LANES | Generic input line C |
| d | input | LANES | Generic input line D |
| p | output | LANES | Generic output line P |
| q | output | LANES | Generic output line Q |
| r | output | LANES | Generic output line R |
| s | output | LANES | Generic output line S |
| q_cost | output | COST_W (5) | Constant quantum cost of the selected gate |
| garbage | output | GARB_W (3) | Constant count of pass-through outputs |

## Verification
The block holds no state, so every output is due in the same cycle its inputs change, and the cost and garbage values are constant from time zero. The bench drives a new input vector on each falling clock edge. It samples a quarter period later, well before the next rising edge, so each check sees the settled result of exactly one vector. All seven gates are instantiated side by side with two lanes. The full 256-vector space of the four two-bit inputs is swept across all of them. Distinctness of outputs is tallied only over the vectors whose unused inputs are zero.

// File: rtl/rgate_pkg.sv
// Package: shared gate selector type and per-gate metadata.
// Assumes: selector order is fixed; the cost and garbage tables follow it.
package rgate_pkg;

    localparam int COST_W = 5;
    localparam int GARB_W = 3;
    localparam int MAX_LINES = 4;

    typedef enum logic [2:0] {
        G_CNOT   = 3'd0,
        G_DCNOT  = 3'd1,
        G_TOFF   = 3'd2,
        G_FRED   = 3'd3,
        G_PERES  = 3'd4,
        G_HNG    = 3'd5,
        G_TR     = 3'd6
    } gate_kind_e;

    // Number of lines (inputs == outputs) used by a gate.
    function automatic int gate_lines(gate_kind_e k);
        case (k)
            G_CNOT:  return 2;
            G_HNG:   return 4;
            default: return 3;
        endcase
    endfunction

    // Quantum cost counted in 1x1/2x2 primitives.
    function automatic logic [COST_W-1:0] gate_cost(gate_kind_e k);
        case (k)
            G_CNOT:  return COST_W'(1);
            G_DCNOT: return COST_W'(2);
            G_TOFF:  return COST_W'(5);
            G_FRED:  return COST_W'(5);
            G_PERES: return COST_W'(4);
            G_HNG:   return COST_W'(6);
            G_TR:    return COST_W'(4);
            default: return COST_W'(0);
        endcase
    endfunction

    // Outputs that only repeat an input unchanged.
    function automatic logic [GARB_W-1:0] gate_garbage(gate_kind_e k);
        case (k)
            G_TOFF, G_HNG: return GARB_W'(2);
            default:       return GARB_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/rg_cnot_cells.sv
// Module: rg_cnot_cell - controlled-NOT, bit-sliced over LANES.
// Assumes: purely combinational; a is the control line.
module rg_cnot_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q
);
    // Forward map: copy control, flip target.
    always_comb begin
        p = a;
        q = a ^ b;
    end

    // Inverse check: target recovered from the outputs (R1, R9).
    always_comb begin
        if (!$isunknown({a, b})) begin
            a_r1_cnot_inverse: assert ((p ^ q) == b && p == a)
                else $error("cnot inverse mismatch");
        end
    end
endmodule

// Module: rg_dcnot_cell - two-target controlled-NOT, bit-sliced.
// Assumes: a controls both b and c.
module rg_dcnot_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic [LANES-1:0] c,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] r
);
    // Forward map: one control fans out to two targets.
    always_comb begin
        p = a;
        q = a ^ b;
        r = a ^ c;
    end

    // Inverse check (R2, R9).
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            a_r2_dcnot_inverse: assert ((p ^ q) == b && (p ^ r) == c)
                else $error("double cnot inverse mismatch");
        end
    end
endmodule

// File: rtl/rg_three_line_cells.sv
// Module: rg_toffoli_cell - doubly controlled NOT, bit-sliced.
// Assumes: a and b are controls, c is the target.
module rg_toffoli_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic [LANES-1:0] c,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] r
);
    // Forward map: flip target where both controls are set.
    always_comb begin
        p = a;
        q = b;
        r = (a & b) ^ c;
    end

    // Self-inverse check: applying the gate again restores c (R3, R9).
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            a_r3_toffoli_inverse: assert (((p & q) ^ r) == c)
                else $error("toffoli inverse mismatch");
        end
    end
endmodule

// Module: rg_fredkin_cell - controlled swap, bit-sliced.
// Assumes: a is the control; b and c exchange where it is 1.
module rg_fredkin_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic [LANES-1:0] c,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] r
);
    // Forward map: per-bit conditional exchange.
    always_comb begin
        p = a;
        q = (~a & b) | (a & c);
        r = (~a & c) | (a & b);
    end

    // Swap conserves ones and is self-inverse (R4, R9).
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            a_r4_fredkin_inverse: assert ((((~p & q) | (p & r)) == b)
                                          && (((~p & r) | (p & q)) == c))
                else $error("fredkin inverse mismatch");
        end
    end
endmodule

// Module: rg_peres_cell - Toffoli followed by controlled-NOT, bit-sliced.
// Assumes: a, b are controls for r; a controls q.
module rg_peres_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic [LANES-1:0] c,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] r
);
    // Forward map.
    always_comb begin
        p = a;
        q = a ^ b;
        r = (a & b) ^ c;
    end

    // Inverse check: recover b first, then c (R5, R9).
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            a_r5_peres_inverse: assert ((r ^ (p & (p ^ q))) == c && (p ^ q) == b)
                else $error("peres inverse mismatch");
        end
    end
endmodule

// Module: rg_tr_cell - TR gate, bit-sliced.
// Assumes: r flips where a is 1 and b is 0.
module rg_tr_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic [LANES-1:0] c,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] r
);
    // Forward map.
    always_comb begin
        p = a;
        q = a ^ b;
        r = (a & ~b) ^ c;
    end

    // Inverse check: recover b, then c (R7, R9).
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            a_r7_tr_inverse: assert ((r ^ (p & ~(p ^ q))) == c && (p ^ q) == b)
                else $error("tr inverse mismatch");
        end
    end
endmodule

// File: rtl/rg_hng_cell.sv
// Module: rg_hng_cell - four-line HNG gate, one full-adder slice per lane.
// Assumes: d = 0 turns (r, s) into (sum, carry) of a + b + c.
module rg_hng_cell #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic [LANES-1:0] c,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] p,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] r,
    output logic [LANES-1:0] s
);
    genvar i;
    for (i = 0; i < LANES; i++) begin : g_lane
        logic prop;
        // Per-lane propagate term shared by sum and carry.
        always_comb prop = a[i] ^ b[i];
        // Per-lane outputs: sum on r, carry folded into d on s.
        always_comb begin
            p[i] = a[i];
            q[i] = b[i];
            r[i] = prop ^ c[i];
            s[i] = (prop & c[i]) ^ (a[i] & b[i]) ^ d[i];
        end
    end

    // Inverse check: c and d recovered from the outputs (R6, R9).
    always_comb begin
        if (!$isunknown({a, b, c, d})) begin
            a_r6_hng_inverse: assert ((r ^ p ^ q) == c
                && (s ^ (((p ^ q) & (r ^ p ^ q)) ^ (p & q))) == d)
                else $error("hng inverse mismatch");
        end
    end
endmodule

// File: rtl/rev_gate_cell.sv
// Module: rev_gate_cell - selects one reversible cell by parameter and exposes
// generic lines a..d / p..s plus constant cost and garbage metadata.
// Assumes: GATE is fixed at elaboration; unused outputs tie to 0.
module rev_gate_cell
    import rgate_pkg::*;
#(
    parameter gate_kind_e GATE  = G_HNG,
    parameter int         LANES = 1
) (
    input  logic [LANES-1:0]  a,
    input  logic [LANES-1:0]  b,
    input  logic [LANES-1:0]  c,
    input  logic [LANES-1:0]  d,
    output logic [LANES-1:0]  p,
    output logic [LANES-1:0]  q,
    output logic [LANES-1:0]  r,
    output logic [LANES-1:0]  s,
    output logic [COST_W-1:0] q_cost,
    output logic [GARB_W-1:0] garbage
);
    localparam int LINES = gate_lines(GATE);

    // Lines left idle by narrower gates are folded here and dropped.
    logic unused_lines;
    assign unused_lines = ^{a, b, c, d};

    // Constant metadata for this configuration.
    assign q_cost  = gate_cost(GATE);
    assign garbage = gate_garbage(GATE);

    case (GATE)
        G_CNOT: begin : g_cnot
            rg_cnot_cell #(.LANES(LANES)) u_cell (.a(a), .b(b), .p(p), .q(q));
            assign r = '0;
            assign s = '0;
        end
        G_DCNOT: begin : g_dcnot
            rg_dcnot_cell #(.LANES(LANES)) u_cell
                (.a(a), .b(b), .c(c), .p(p), .q(q), .r(r));
            assign s = '0;
        end
        G_TOFF: begin : g_toff
            rg_toffoli_cell #(.LANES(LANES)) u_cell
                (.a(a), .b(b), .c(c), .p(p), .q(q), .r(r));
            assign s = '0;
        end
        G_FRED: begin : g_fred
            rg_fredkin_cell #(.LANES(LANES)) u_cell
                (.a(a), .b(b), .c(c), .p(p), .q(q), .r(r));
            assign s = '0;
        end
        G_PERES: begin : g_peres
            rg_peres_cell #(.LANES(LANES)) u_cell
                (.a(a), .b(b), .c(c), .p(p), .q(q), .r(r));
            assign s = '0;
        end
        G_TR: begin : g_tr
            rg_tr_cell #(.LANES(LANES)) u_cell
                (.a(a), .b(b), .c(c), .p(p), .q(q), .r(r));
            assign s = '0;
        end
        default: begin : g_hng
            rg_hng_cell #(.LANES(LANES)) u_cell
                (.a(a), .b(b), .c(c), .d(d), .p(p), .q(q), .r(r), .s(s));
        end
    endcase

    // Idle output lines stay low; pass-through count fits the line count.
    always_comb begin
        if (!$isunknown({p, q, r, s})) begin
            a_r8_idle_low: assert ((LINES > 3 || s == '0) && (LINES > 2 || r == '0))
                else $error("idle output line driven");
            a_r10_garbage_fits: assert (int'(garbage) < LINES && garbage != '0)
                else $error("garbage count out of range");
        end
    end
endmodule

// File: tb/tb_rev_gate_cell.sv
module tb_rev_gate_cell;
    import rgate_pkg::*;

    localparam int NG = 7;
    localparam int LN = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [LN-1:0] a, b, c, d;
    logic [LN-1:0] p_w [NG];
    logic [LN-1:0] q_w [NG];
    logic [LN-1:0] r_w [NG];
    logic [LN-1:0] s_w [NG];
    logic [COST_W-1:0] cost_w [NG];
    logic [GARB_W-1:0] garb_w [NG];

    for (genvar k = 0; k < NG; k++) begin : g_k
        rev_gate_cell #(.GATE(gate_kind_e'(k)), .LANES(LN)) dut (
            .a(a), .b(b), .c(c), .d(d),
            .p(p_w[k]), .q(q_w[k]), .r(r_w[k]), .s(s_w[k]),
            .q_cost(cost_w[k]), .garbage(garb_w[k]));
    end

    int errors = 0;
    int checks = 0;
    int width_t [NG] = '{2, 3, 3, 3, 3, 4, 3};
    int cost_t  [NG] = '{1, 2, 5, 5, 4, 6, 4};
    int garb_t  [NG] = '{1, 1, 2, 1, 1, 2, 1};
    bit seen [NG][256];
    int distinct [NG];

    // Expected {s,r,q,p}, two lanes each, from the requirement equations.
    function automatic logic [7:0] model(int k, logic [1:0] ia, logic [1:0] ib,
                                         logic [1:0] ic, logic [1:0] id);
        logic [1:0] ep, eq, er, es;
        ep = 0; eq = 0; er = 0; es = 0;
        for (int l = 0; l < LN; l++) begin
            int x, y, z, w, tot;
            x = ia[l]; y = ib[l]; z = ic[l]; w = id[l];
            case (k)
                0: begin ep[l] = x[0]; eq[l] = (x != y); end
                1: begin ep[l] = x[0]; eq[l] = (x != y); er[l] = (x != z); end
                2: begin ep[l] = x[0]; eq[l] = y[0]; er[l] = ((x * y) != z); end
                3: begin ep[l] = x[0]; eq[l] = x ? z[0] : y[0]; er[l] = x ? y[0] : z[0]; end
                4: begin ep[l] = x[0]; eq[l] = (x != y); er[l] = ((x * y) != z); end
                5: begin
                    tot = x + y + z;
                    ep[l] = x[0]; eq[l] = y[0]; er[l] = tot[0];
                    es[l] = ((tot / 2) != w);
                end
                default: begin ep[l] = x[0]; eq[l] = (x != y); er[l] = ((x * (1 - y)) != z); end
            endcase
        end
        return {es, er, eq, ep};
    endfunction

    task automatic check(bit ok, string req, int k, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s gate=%0d actual=%0h expected=%0h", req, k, act, exp);
        end
    endtask

    function automatic string req_of(int k);
        case (k)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
            4: return "R5"; 5: return "R6"; default: return "R7";
        endcase
    endfunction

    initial begin
        a = 0; b = 0; c = 0; d = 0;
        for (int k = 0; k < NG; k++) distinct[k] = 0;
        @(negedge clk); #5;
        // Initial state: all-zero inputs give all-zero outputs; metadata constant.
        for (int k = 0; k < NG; k++) begin
            check({s_w[k], r_w[k], q_w[k], p_w[k]} == 8'h00, req_of(k), k,
                  {s_w[k], r_w[k], q_w[k], p_w[k]}, 0);
            check(int'(cost_w[k]) == cost_t[k], req_of(k), k, cost_w[k], cost_t[k]);
            check(int'(garb_w[k]) == garb_t[k], "R10", k, garb_w[k], garb_t[k]);
        end
        // Full sweep of the two-lane input space (R1-style checks per gate, R8, R9, R11).
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            a = v[1:0]; b = v[3:2]; c = v[5:4]; d = v[7:6];
            #5;
            for (int k = 0; k < NG; k++) begin
                logic [7:0] act, exp, amask;
                bit active_only;
                act = {s_w[k], r_w[k], q_w[k], p_w[k]};
                amask = (width_t[k] == 2) ? 8'h0F : (width_t[k] == 3) ? 8'h3F : 8'hFF;
                // Model ignores lines above the active width: R8 and R11.
                exp = model(k, a, b, c, d) & amask;
                active_only = ((v & ~int'(amask)) == 0);
                if (active_only)
                    check(act == exp, req_of(k), k, act, exp);
                else
                    check(act == exp, "R8", k, act, exp);
                if (active_only) begin
                    if (seen[k][act]) begin
                        check(1'b0, "R9", k, act, v);
                    end else begin
                        seen[k][act] = 1'b1;
                        distinct[k]++;
                    end
                end
            end
        end
        // R9: every active vector mapped to its own output.
        for (int k = 0; k < NG; k++)
            check(distinct[k] == (1 << (LN * width_t[k])), "R9", k,
                  distinct[k], 1 << (LN * width_t[k]));
        // R6: full-adder use with d=0, lane 1 only set (R11 lane isolation).
        @(negedge clk);
        a = 2'b10; b = 2'b10; c = 2'b10; d = 2'b00;
        #5;
        check(r_w[5] == 2'b10 && s_w[5] == 2'b10, "R6", 5, {s_w[5], r_w[5]}, 4'b1010);
        check(p_w[0] == 2'b10 && q_w[0] == 2'b00, "R11", 0, {q_w[0], p_w[0]}, 4'b0010);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule